// File: doc/BRIEF.md
# In-Order Superscalar Issue Grouper

This block sits between instruction decode and execution in an in-order superscalar pipeline. It holds a small window of decoded instructions, oldest first, and each cycle decides how many of them leave together as one issue group. An instruction joins the group only when it is valid and every older instruction in the window has already joined. It must also not read a register that an older group member writes, and it must not be a second memory access in the same cycle, since the data cache has one port. The first instruction that fails any of these tests closes the group, so nothing younger than it can issue in that cycle.

Instructions that do not issue move to the front of the window. Decode offers a bundle of up to four new instructions every cycle. The block takes the leading valid entries of that bundle that fit in the freed slots and reports how many it took, so decode can offer the rest again. Two free-running counters record elapsed cycles and issued instructions, which gives a direct measure of the throughput the grouping rules allow.

Top module: `issue_grouper`

## Requirements
- R1: No more than four instructions (the window depth) issue in a cycle, and `issue_cnt` always equals the number of set bits in `issue_en`.
- R2: Issue is strictly in program order: `issue_en` is always a contiguous run of ones starting at bit 0 (slot 0 is the oldest), so a blocked slot blocks every younger slot in that cycle.
- R3: A slot whose `src_a` or `src_b` equals the `dst` of an older slot in the same window does not issue that cycle. A producer that issued in an earlier cycle never blocks it.
- R4: At most one slot with its memory flag set issues per cycle. A second memory operation closes the group and issues in a later cycle.
- R5: Register index 0 never creates a dependency, whether it appears as a destination or as a source.
- R6: An invalid slot closes the group, and an empty window issues nothing.
- R7: The window outputs show, in order, the slots that did not issue, followed by the newly taken instructions. Unused slots read as all zeros.
- R8: `take_cnt` equals the smaller of the number of free window slots after issue and the number of leading set bits of `in_valid`. Bundle entries 0 to `take_cnt`-1 are appended in order behind the remaining instructions.
- R9: `cycle_count` increases by one on every clock edge where reset is low.
- R10: `instr_count` increases by the current `issue_cnt` on every clock edge where reset is low.
- R11: A clock edge with `rst` high (synchronous, active high) empties the window and clears both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Valid bit per offered instruction, entry 0 oldest |
| in_mem | input | 4 | Memory-operation flag per offered instruction |
| in_dst | input | 20 | Destination register per entry, 5 bits each, entry k at bits 5k+4:5k |
| in_src_a | input | 20 | First source register per entry, same packing |
| in_src_b | input | 20 | Second source register per entry, same packing |
| take_cnt | output | 3 | Number of leading bundle entries accepted this cycle |
| win_valid | output | 4 | Valid bit of each window slot, slot 0 oldest |
| win_mem | output | 4 | Memory flag of each window slot |
| win_dst | output | 20 | Destination register of each window slot |
| win_src_a | output | 20 | First source register of each window slot |
| win_src_b | output | 20 | Second source register of each window slot |
| issue_en | output | 4 | Per-slot issue enable this cycle |
| issue_cnt | output | 3 | Number of slots issuing this cycle |
| cycle_count | output | 32 | Elapsed cycles since reset |
| instr_count | output | 32 | Instructions issued since reset |

## Verification
`issue_en`, `issue_cnt` and `take_cnt` are combinational functions of the registered window and the offered bundle, so they are due in the same cycle the bundle is driven. The window contents and both counters change one clock edge later. The bench drives each bundle at the falling edge and samples all outputs one time unit later. It checks the combinational results against a reference window kept in the bench for that same cycle. It checks the window and counter outputs against the state the reference reached after the previous rising edge. After a reset release it counts the single edge already taken with an empty bundle, so the first expected `cycle_count` is one.

// File: rtl/issue_grp_pkg.sv
package issue_grp_pkg;

  localparam int REG_W = 5;

  typedef logic [REG_W-1:0] reg_idx_t;

  typedef struct packed {
    logic     valid;
    logic     mem;
    reg_idx_t dst;
    reg_idx_t src_a;
    reg_idx_t src_b;
  } slot_t;

  localparam slot_t EMPTY_SLOT = '0;

  // True when the instruction reads architectural register r (r0 excluded).
  function automatic logic reads_reg(input slot_t y, input reg_idx_t r);
    return (r != '0) && ((y.src_a == r) || (y.src_b == r));
  endfunction

  // Same-group read-after-write between an older and a younger slot.
  function automatic logic raw_dep(input slot_t older, input slot_t younger);
    return older.valid && younger.valid && reads_reg(younger, older.dst);
  endfunction

endpackage

// File: rtl/issue_hazard.sv
module issue_hazard
  import issue_grp_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  slot_t            win [SLOTS],
  output logic [SLOTS-1:0] issue_en,
  output logic [CW-1:0]    issue_cnt
);

  function automatic logic [CW-1:0] ones(input logic [SLOTS-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < SLOTS; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  // Named hazard events, one bit per slot.
  logic [SLOTS-1:0] valid_v;
  logic [SLOTS-1:0] mem_v;
  logic [SLOTS-1:0] raw_hit;
  logic [SLOTS-1:0] mem_clash;
  logic [SLOTS-1:0] stop;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      valid_v[i] = win[i].valid;
      mem_v[i]   = win[i].valid & win[i].mem;
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      raw_hit[i]   = 1'b0;
      mem_clash[i] = 1'b0;
      for (int j = 0; j < SLOTS; j++) begin
        if (j < i) begin
          raw_hit[i]   = raw_hit[i] | raw_dep(win[j], win[i]);
          mem_clash[i] = mem_clash[i] | (mem_v[j] & mem_v[i]);
        end
      end
      stop[i] = ~valid_v[i] | raw_hit[i] | mem_clash[i];
    end
  end

  // Group closes at the first stopping slot: prefix chain.
  assign issue_en[0] = ~stop[0];
  for (genvar g = 1; g < SLOTS; g++) begin : g_chain
    assign issue_en[g] = issue_en[g-1] & ~stop[g];

    // R2
    prefix_order_chk: assert property (@(posedge clk) disable iff (rst)
      issue_en[g] |-> issue_en[g-1]);
  end

  assign issue_cnt = ones(issue_en);

  // R4
  single_mem_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(issue_en & mem_v) <= 1);

  // R6
  invalid_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_en & ~valid_v) == '0);

endmodule

// File: rtl/issue_window.sv
module issue_window
  import issue_grp_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  slot_t         incoming [SLOTS],
  input  logic [CW-1:0] issue_cnt,
  output slot_t         win [SLOTS],
  output logic [CW-1:0] take_cnt
);

  function automatic logic [CW-1:0] lead_count(input logic [SLOTS-1:0] v);
    logic [CW-1:0] n;
    logic          brk;
    n   = '0;
    brk = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!v[i]) brk = 1'b1;
      else if (!brk) n = n + 1'b1;
    end
    return n;
  endfunction

  slot_t            win_q [SLOTS];
  slot_t            win_d [SLOTS];
  logic [SLOTS-1:0] win_v;
  logic [SLOTS-1:0] in_v;
  logic [CW-1:0]    occ;
  logic [CW-1:0]    remain;
  logic [CW-1:0]    free_cnt;
  logic [CW-1:0]    in_lead;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      win_v[i] = win_q[i].valid;
      in_v[i]  = incoming[i].valid;
    end
  end

  always_comb begin
    occ      = lead_count(win_v);
    remain   = occ - issue_cnt;
    free_cnt = CW'(SLOTS) - remain;
    in_lead  = lead_count(in_v);
    take_cnt = (in_lead < free_cnt) ? in_lead : free_cnt;
  end

  // Compact survivors to the front, then append accepted entries.
  always_comb begin
    for (int k = 0; k < SLOTS; k++) begin
      win_d[k] = EMPTY_SLOT;
      for (int j = 0; j < SLOTS; j++) begin
        if ((k < int'(remain)) && (j == k + int'(issue_cnt)))
          win_d[k] = win_q[j];
        if ((k >= int'(remain)) && (j == k - int'(remain)) && (j < int'(take_cnt)))
          win_d[k] = incoming[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < SLOTS; k++) begin
      if (rst) win_q[k] <= EMPTY_SLOT;
      else     win_q[k] <= win_d[k];
    end
  end

  assign win = win_q;

  // R8
  take_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (take_cnt <= free_cnt) && (take_cnt <= in_lead));

  // R7
  occupancy_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (occ == $past(remain) + $past(take_cnt)));

  // R6
  issue_within_occ_chk: assert property (@(posedge clk) disable iff (rst)
    issue_cnt <= occ);

  // R11
  window_reset_chk: assert property (@(posedge clk)
    rst |=> (win_v == '0));

endmodule

// File: rtl/issue_counters.sv
module issue_counters #(
  parameter int SLOTS = 4,
  parameter int CNT_W = 32,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    issue_cnt,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic [CNT_W-1:0] instr_cnt
);

  function automatic logic [CNT_W-1:0] accumulate(input logic [CNT_W-1:0] total,
                                                 input logic [CW-1:0]    add);
    return total + CNT_W'(add);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_cnt <= '0;
      instr_cnt <= '0;
    end else begin
      cycle_cnt <= accumulate(cycle_cnt, CW'(1));
      instr_cnt <= accumulate(instr_cnt, issue_cnt);
    end
  end

  // R9
  cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cycle_cnt == $past(cycle_cnt) + 1'b1));

  // R10
  instr_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (instr_cnt == $past(instr_cnt) + CNT_W'($past(issue_cnt))));

  // R11
  counter_reset_chk: assert property (@(posedge clk)
    rst |=> (cycle_cnt == '0) && (instr_cnt == '0));

endmodule

// File: rtl/issue_grouper.sv
module issue_grouper
  import issue_grp_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SLOTS-1:0]         in_valid,
  input  logic [SLOTS-1:0]         in_mem,
  input  logic [SLOTS*REG_W-1:0]   in_dst,
  input  logic [SLOTS*REG_W-1:0]   in_src_a,
  input  logic [SLOTS*REG_W-1:0]   in_src_b,
  output logic [$clog2(SLOTS+1)-1:0] take_cnt,
  output logic [SLOTS-1:0]         win_valid,
  output logic [SLOTS-1:0]         win_mem,
  output logic [SLOTS*REG_W-1:0]   win_dst,
  output logic [SLOTS*REG_W-1:0]   win_src_a,
  output logic [SLOTS*REG_W-1:0]   win_src_b,
  output logic [SLOTS-1:0]         issue_en,
  output logic [$clog2(SLOTS+1)-1:0] issue_cnt,
  output logic [CNT_W-1:0]         cycle_count,
  output logic [CNT_W-1:0]         instr_count
);

  localparam int CW = $clog2(SLOTS + 1);

  slot_t incoming [SLOTS];
  slot_t win      [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_lanes
    assign incoming[g] = '{valid: in_valid[g],
                           mem:   in_mem[g],
                           dst:   in_dst[g*REG_W +: REG_W],
                           src_a: in_src_a[g*REG_W +: REG_W],
                           src_b: in_src_b[g*REG_W +: REG_W]};
    assign win_valid[g]                = win[g].valid;
    assign win_mem[g]                  = win[g].mem;
    assign win_dst[g*REG_W +: REG_W]   = win[g].dst;
    assign win_src_a[g*REG_W +: REG_W] = win[g].src_a;
    assign win_src_b[g*REG_W +: REG_W] = win[g].src_b;
  end

  issue_window #(.SLOTS(SLOTS)) u_window (
    .clk       (clk),
    .rst       (rst),
    .incoming  (incoming),
    .issue_cnt (issue_cnt),
    .win       (win),
    .take_cnt  (take_cnt)
  );

  issue_hazard #(.SLOTS(SLOTS)) u_hazard (
    .clk       (clk),
    .rst       (rst),
    .win       (win),
    .issue_en  (issue_en),
    .issue_cnt (issue_cnt)
  );

  issue_counters #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_counters (
    .clk       (clk),
    .rst       (rst),
    .issue_cnt (issue_cnt),
    .cycle_cnt (cycle_count),
    .instr_cnt (instr_count)
  );

  // R1
  issue_count_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_cnt == CW'($countones(issue_en))) && (int'(issue_cnt) <= SLOTS));

endmodule

// File: tb/issue_grouper_test.sv
`timescale 1ns/100ps
module issue_grouper_test;
  import issue_grp_pkg::*;

  localparam int S  = 4;
  localparam int RW = REG_W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [S-1:0]    in_valid = '0, in_mem = '0;
  logic [S*RW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic [2:0]      take_cnt, issue_cnt;
  logic [S-1:0]    win_valid, win_mem, issue_en;
  logic [S*RW-1:0] win_dst, win_src_a, win_src_b;
  logic [31:0]     cycle_count, instr_count;

  issue_grouper uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mem(in_mem),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .take_cnt(take_cnt), .win_valid(win_valid), .win_mem(win_mem),
    .win_dst(win_dst), .win_src_a(win_src_a), .win_src_b(win_src_b),
    .issue_en(issue_en), .issue_cnt(issue_cnt),
    .cycle_count(cycle_count), .instr_count(instr_count)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  longint exp_cycles = 0;
  longint exp_instr  = 0;

  // Reference window and offered bundle.
  int mv[S], mm[S], md[S], ma[S], mb[S];
  int bv[S], bm[S], bd[S], ba[S], bb[S];

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_bundle();
    for (int k = 0; k < S; k++) begin
      bv[k] = 0; bm[k] = 0; bd[k] = 0; ba[k] = 0; bb[k] = 0;
    end
  endtask

  task automatic set_slot(input int k, input int v, input int m,
                          input int d, input int a, input int b);
    bv[k] = v; bm[k] = m; bd[k] = d; ba[k] = a; bb[k] = b;
  endtask

  task automatic clear_model();
    for (int k = 0; k < S; k++) begin
      mv[k] = 0; mm[k] = 0; md[k] = 0; ma[k] = 0; mb[k] = 0;
    end
  endtask

  task automatic drive_bundle();
    for (int k = 0; k < S; k++) begin
      in_valid[k]          = bv[k][0];
      in_mem[k]            = bm[k][0];
      in_dst[k*RW +: RW]   = RW'(bd[k]);
      in_src_a[k*RW +: RW] = RW'(ba[k]);
      in_src_b[k*RW +: RW] = RW'(bb[k]);
    end
  endtask

  // One cycle: drive at falling edge, sample 1 ns later, advance reference.
  task automatic step(input int exp_n, input int exp_take, input string tag);
    int n, occ, lead, free_s, take, rem, seen_mem, dep;
    bit stop;
    int nv[S], nm[S], nd[S], na[S], nb[S];
    longint act_key, exp_key;
    @(negedge clk);
    drive_bundle();
    #1;
    n = 0; seen_mem = 0; stop = 0;
    for (int i = 0; i < S; i++) begin
      if (!stop) begin
        dep = 0;
        for (int j = 0; j < i; j++)
          if (md[j] != 0 && (md[j] == ma[i] || md[j] == mb[i])) dep = 1;
        if (mv[i] == 0 || dep != 0 || (mm[i] != 0 && seen_mem != 0)) stop = 1;
        else begin
          if (mm[i] != 0) seen_mem = 1;
          n++;
        end
      end
    end
    occ = 0;
    for (int i = 0; i < S; i++) if (mv[i] != 0) occ++;
    lead = 0; stop = 0;
    for (int i = 0; i < S; i++) begin
      if (bv[i] == 0) stop = 1;
      else if (!stop) lead++;
    end
    rem    = occ - n;
    free_s = S - rem;
    take   = (lead < free_s) ? lead : free_s;

    check("R1 issue_cnt", issue_cnt, n);
    check("R2/R3/R4/R5/R6 issue_en", issue_en, (64'd1 << n) - 1);
    check("R8 take_cnt", take_cnt, take);
    for (int k = 0; k < S; k++) begin
      act_key = {win_valid[k], win_mem[k], win_dst[k*RW +: RW],
                 win_src_a[k*RW +: RW], win_src_b[k*RW +: RW]};
      exp_key = (longint'(mv[k]) << 16) | (longint'(mm[k]) << 15) |
                (longint'(md[k]) << 10) | (longint'(ma[k]) << 5) | longint'(mb[k]);
      check("R7 window slot contents", act_key, exp_key);
    end
    check("R9 cycle_count", cycle_count, exp_cycles);
    check("R10 instr_count", instr_count, exp_instr);
    if (exp_n >= 0)    check(tag, issue_cnt, exp_n);
    if (exp_take >= 0) check("R8 directed take_cnt", take_cnt, exp_take);

    for (int k = 0; k < S; k++) begin
      nv[k] = 0; nm[k] = 0; nd[k] = 0; na[k] = 0; nb[k] = 0;
      if (k < rem) begin
        nv[k] = mv[k+n]; nm[k] = mm[k+n]; nd[k] = md[k+n];
        na[k] = ma[k+n]; nb[k] = mb[k+n];
      end else if (k - rem < take) begin
        nv[k] = 1; nm[k] = bm[k-rem]; nd[k] = bd[k-rem];
        na[k] = ba[k-rem]; nb[k] = bb[k-rem];
      end
    end
    for (int k = 0; k < S; k++) begin
      mv[k] = nv[k]; mm[k] = nm[k]; md[k] = nd[k]; ma[k] = na[k]; mb[k] = nb[k];
    end
    exp_instr  += n;
    exp_cycles += 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    clear_bundle();
    drive_bundle();
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R11 window empty after reset", win_valid, 0);
    check("R11 cycle_count cleared", cycle_count, 0);
    check("R11 instr_count cleared", instr_count, 0);
    check("R6 empty window issues none", issue_cnt, 0);
    clear_model();
    exp_instr  = 0;
    exp_cycles = 1;  // release edge is taken with an empty bundle
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_bundle();
    clear_model();
    do_reset();

    // R3: chain of dependencies inside the window.
    set_slot(0, 1, 0, 1, 2, 3);
    set_slot(1, 1, 0, 4, 1, 0);
    set_slot(2, 1, 0, 5, 6, 7);
    set_slot(3, 1, 0, 6, 4, 0);
    step(0, 4, "R6 empty window issues none");
    clear_bundle();
    step(1, 0, "R3 read of r1 stops group at slot 1");
    step(2, 0, "R3 read of r4 stops group at slot 2");
    step(1, 0, "R3 producer from earlier cycle does not block");

    // R5: register 0 everywhere.
    for (int k = 0; k < S; k++) set_slot(k, 1, 0, 0, 0, 0);
    step(0, 4, "R6 empty window issues none");
    clear_bundle();
    step(4, 0, "R5 register 0 creates no dependency");

    // R4: two memory operations in one window.
    set_slot(0, 1, 0, 1, 2, 3);
    set_slot(1, 1, 1, 4, 5, 6);
    set_slot(2, 1, 1, 7, 8, 9);
    set_slot(3, 1, 0, 10, 11, 12);
    step(0, 4, "R6 empty window issues none");
    clear_bundle();
    step(2, 0, "R4 second memory op closes group");
    step(2, 0, "R4 held memory op issues next cycle");

    // R8: bundle with a hole, then a partial fill.
    set_slot(0, 1, 0, 1, 0, 0);
    set_slot(1, 1, 0, 2, 1, 0);
    set_slot(2, 0, 0, 0, 0, 0);
    set_slot(3, 1, 0, 3, 0, 0);
    step(0, 2, "R6 empty window issues none");
    for (int k = 0; k < S; k++) set_slot(k, 1, 0, 20 + k, 0, 0);
    step(1, 3, "R3 dependent slot held while bundle partially taken");
    clear_bundle();
    step(-1, 0, "drain");
    step(-1, 0, "drain");

    // Near-exhaustive sweep over a small register space.
    for (int t = 0; t < 3000; t++) begin
      if (t == 1500) do_reset();
      for (int k = 0; k < S; k++)
        set_slot(k, ($urandom_range(0, 9) < 8) ? 1 : 0,
                 ($urandom_range(0, 2) == 0) ? 1 : 0,
                 $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
      step(-1, -1, "sweep");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule